// File: doc/BRIEF.md
# Crosslet Cross-Correlator Cell

This block builds a visibility matrix out of complex subband samples called crosslets. A block of local crosslets arrives serially on one stream. Each beat carries one crosslet, and the signal inputs are interleaved within each crosslet index. A valid local block is first correlated against itself. It then stays in a rotating store, and every remote block that later arrives from the ring is correlated against that store. Each remote block carries one crosslet per input and per crosslet index, all in a single beat. After each valid remote block the store shifts by one slot. After as many remote blocks as there are inputs, every pairing of a local input with a remote input has been visited once.

Each product is `a * conj(b)`. It is added into wide signed real and imaginary accumulators. There are two matrices, one for local-by-local pairs and one for local-by-remote pairs. Each matrix has one entry per crosslet index, per row input and per column input. A sync pulse copies the accumulators and the valid and flagged block counts into a readable bank, and starts a new integration. A registered read port returns one bank entry per address. Blocks that carry a flag are counted and otherwise have no effect.

Top module: `xcorr_cell`

## Requirements
- R1: After reset, every bank entry, both snapshot counts and the read outputs are zero, and no local block is held.
- R2: Local beat number b, counted from 0, carries crosslet index b / NI and input b % NI. A local block ends on beat NX*NI-1. The block is flagged if `loc_flag` is high on any of its beats.
- R3: A valid local block is loaded at its last beat. During the NI cycles after that, entry (local, x, i, j) receives L[x][i]*conj(L[x][j]) once, for all x, i and j.
- R4: A remote block is accepted when a local block is held and no local pass is running. An accepted valid remote block with rotation r adds L[x][(j+r)%NI]*conj(Rm[x][j]) to entry (remote, x, (j+r)%NI, j) in the cycle it is accepted. Rm[x][j] sits at bits [(x*NI+j)*W +: W] of the remote buses.
- R5: Loading a local block sets the rotation to 0. Each accepted valid remote block advances the rotation by one, modulo NI.
- R6: A remote block that arrives while no local block is held, or while a local pass is running, is dropped. It adds no products, is not counted and does not rotate the store.
- R7: A flagged block increments the flagged count and adds no products. A flagged local block does not replace the held crosslets, and a flagged remote block does not rotate the store.
- R8: The valid count increases by one for each loaded local block and for each accepted valid remote block.
- R9: On a cycle with `sync` high, the bank and the snapshot counts take the values accumulated before that cycle. The accumulators and counters restart from that cycle's own contributions. Between syncs, the snapshot counts do not change.
- R10: Read address ((k*NX+x)*NI+i)*NI+j selects matrix k (0 for local, 1 for remote), crosslet index x, row i and column j. The data appears on `rd_re` and `rd_im` one cycle after the address. Addresses beyond the last entry read zero.
- R11: A product a*conj(b) has real part ar*br+ai*bi and imaginary part ai*br-ar*bi. It is accumulated in ACC_W-bit two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync | input | 1 | End of integration: snapshot and restart |
| loc_valid | input | 1 | Local crosslet beat present |
| loc_flag | input | 1 | Marks the current local block as flagged |
| loc_re | input | W | Local crosslet, real part |
| loc_im | input | W | Local crosslet, imaginary part |
| rem_valid | input | 1 | Remote block present |
| rem_flag | input | 1 | Remote block is flagged |
| rem_re | input | NX*NI*W | Remote crosslets, real parts |
| rem_im | input | NX*NI*W | Remote crosslets, imaginary parts |
| rd_addr | input | clog2(2*NX*NI*NI) | Bank read address |
| rd_re | output | ACC_W | Bank entry, real part |
| rd_im | output | ACC_W | Bank entry, imaginary part |
| snap_valid | output | CNT_W | Valid blocks in the last integration |
| snap_flag | output | CNT_W | Flagged blocks in the last integration |

## Verification
Local-pass products reach the accumulators over the NI rising edges that follow the edge taking the last local beat. A remote block's products and count land at the edge where it is accepted. The bank and the snapshot counts change only at an edge where `sync` is high, and read data follows its address by one edge. The bench model therefore applies every contribution at the same rising edge, captures the expected read value from the bank as it was before that edge, and compares all outputs at the next falling edge. Stimulus is placed so that the cases of interest are hit: a remote block inside a local pass, and a remote block in the sync cycle.

// File: rtl/xcorr_pkg.sv
package xcorr_pkg;

   typedef enum logic {MAT_LOCAL = 1'b0, MAT_REMOTE = 1'b1} mat_kind_e;

   // flat position of one visibility in the bank
   function automatic int unsigned vis_index(int unsigned kind, int unsigned x,
                                             int unsigned i, int unsigned j,
                                             int unsigned nx, int unsigned ni);
      return ((kind * nx + x) * ni + i) * ni + j;
   endfunction

endpackage

// File: rtl/xcorr_local_collect.sv
module xcorr_local_collect #(
   parameter int NX = 2,
   parameter int NI = 12,
   parameter int W  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                beat_valid,
   input  logic                beat_flag,
   input  logic signed [W-1:0] beat_re,
   input  logic signed [W-1:0] beat_im,
   output logic                blk_done,
   output logic                blk_flag,
   output logic signed [W-1:0] blk_re [NX*NI],
   output logic signed [W-1:0] blk_im [NX*NI]
);
   localparam int N    = NX * NI;
   localparam int BW   = (N > 1) ? $clog2(N) : 1;
   localparam int LAST = N - 1;

   logic [BW-1:0]       beat_cnt;
   logic                flag_seen;
   logic signed [W-1:0] sh_re [N];
   logic signed [W-1:0] sh_im [N];

   assign blk_done = beat_valid && (beat_cnt == BW'(LAST));
   assign blk_flag = flag_seen | beat_flag;

   // the final beat goes straight through to the block output
   for (genvar n = 0; n < N; n++) begin : g_merge
      assign blk_re[n] = (beat_valid && beat_cnt == BW'(n)) ? beat_re : sh_re[n];
      assign blk_im[n] = (beat_valid && beat_cnt == BW'(n)) ? beat_im : sh_im[n];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_cnt  <= '0;
         flag_seen <= 1'b0;
         for (int n = 0; n < N; n++) begin
            sh_re[n] <= '0;
            sh_im[n] <= '0;
         end
      end else if (beat_valid) begin
         sh_re[beat_cnt] <= beat_re;
         sh_im[beat_cnt] <= beat_im;
         if (beat_cnt == BW'(LAST)) begin
            beat_cnt  <= '0;
            flag_seen <= 1'b0;
         end else begin
            beat_cnt  <= beat_cnt + 1'b1;
            flag_seen <= flag_seen | beat_flag;
         end
      end
   end
endmodule

// File: rtl/xcorr_barrel.sv
module xcorr_barrel #(
   parameter int NX = 2,
   parameter int NI = 12,
   parameter int W  = 8,
   parameter int RW = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic signed [W-1:0] load_re [NX*NI],
   input  logic signed [W-1:0] load_im [NX*NI],
   input  logic                rem_take,
   output logic signed [W-1:0] slot_re [NX*NI],
   output logic signed [W-1:0] slot_im [NX*NI],
   output logic signed [W-1:0] ref_re  [NX*NI],
   output logic signed [W-1:0] ref_im  [NX*NI],
   output logic [RW-1:0]       rot,
   output logic                pass_on,
   output logic                held
);
   localparam int N  = NX * NI;
   localparam int PW = $clog2(NI + 1);

   logic [PW-1:0] pass_cnt;
   logic          step;

   assign pass_on = (pass_cnt != '0);
   assign step    = pass_on | rem_take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pass_cnt <= '0;
         rot      <= '0;
         held     <= 1'b0;
         for (int n = 0; n < N; n++) begin
            slot_re[n] <= '0;
            slot_im[n] <= '0;
            ref_re[n]  <= '0;
            ref_im[n]  <= '0;
         end
      end else if (load) begin
         pass_cnt <= PW'(NI);
         rot      <= '0;
         held     <= 1'b1;
         for (int n = 0; n < N; n++) begin
            slot_re[n] <= load_re[n];
            slot_im[n] <= load_im[n];
            ref_re[n]  <= load_re[n];
            ref_im[n]  <= load_im[n];
         end
      end else if (step) begin
         if (pass_on) pass_cnt <= pass_cnt - 1'b1;
         rot <= (rot == RW'(NI - 1)) ? '0 : rot + 1'b1;
         // slot s takes slot s+1 within its crosslet row
         for (int n = 0; n < N; n++) begin
            slot_re[n] <= slot_re[(n / NI) * NI + ((n % NI) + 1) % NI];
            slot_im[n] <= slot_im[(n / NI) * NI + ((n % NI) + 1) % NI];
         end
      end
   end
endmodule

// File: rtl/xcorr_cmul_array.sv
module xcorr_cmul_array #(
   parameter int N  = 24,
   parameter int W  = 8,
   parameter int PW = 17
) (
   input  logic signed [W-1:0]  a_re [N],
   input  logic signed [W-1:0]  a_im [N],
   input  logic signed [W-1:0]  b_re [N],
   input  logic signed [W-1:0]  b_im [N],
   output logic signed [PW-1:0] p_re [N],
   output logic signed [PW-1:0] p_im [N]
);
   // a times the conjugate of b, one lane per crosslet
   for (genvar n = 0; n < N; n++) begin : g_lane
      assign p_re[n] = PW'(a_re[n]) * PW'(b_re[n]) + PW'(a_im[n]) * PW'(b_im[n]);
      assign p_im[n] = PW'(a_im[n]) * PW'(b_re[n]) - PW'(a_re[n]) * PW'(b_im[n]);
   end
endmodule

// File: rtl/xcorr_acc_bank.sv
module xcorr_acc_bank #(
   parameter int NX    = 2,
   parameter int NI    = 12,
   parameter int PW    = 17,
   parameter int ACC_W = 32,
   parameter int RW    = 4,
   parameter int AW    = 10
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en_loc,
   input  logic                    en_rem,
   input  logic                    sync,
   input  logic [RW-1:0]           rot,
   input  logic signed [PW-1:0]    p_re [NX*NI],
   input  logic signed [PW-1:0]    p_im [NX*NI],
   input  logic [AW-1:0]           rd_addr,
   output logic signed [ACC_W-1:0] rd_re,
   output logic signed [ACC_W-1:0] rd_im
);
   localparam int TOT = 2 * NX * NI * NI;

   logic signed [ACC_W-1:0] bank_re [TOT];
   logic signed [ACC_W-1:0] bank_im [TOT];
   logic                    en_kind [2];

   assign en_kind[xcorr_pkg::MAT_LOCAL]  = en_loc;
   assign en_kind[xcorr_pkg::MAT_REMOTE] = en_rem;

   for (genvar k = 0; k < 2; k++) begin : g_kind
      for (genvar x = 0; x < NX; x++) begin : g_x
         for (genvar i = 0; i < NI; i++) begin : g_row
            for (genvar j = 0; j < NI; j++) begin : g_col
               localparam int unsigned E  = xcorr_pkg::vis_index(k, x, i, j, NX, NI);
               localparam int unsigned RS = (i + NI - j) % NI;
               localparam int unsigned P  = x * NI + j;
               logic                    hit;
               logic signed [ACC_W-1:0] c_re, c_im, a_re, a_im, b_re, b_im;
               // column j meets row i when the store has turned by i-j
               assign hit  = en_kind[k] && (rot == RW'(RS));
               assign c_re = hit ? ACC_W'(p_re[P]) : '0;
               assign c_im = hit ? ACC_W'(p_im[P]) : '0;
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) begin
                     a_re <= '0; a_im <= '0; b_re <= '0; b_im <= '0;
                  end else if (sync) begin
                     b_re <= a_re; b_im <= a_im;
                     a_re <= c_re; a_im <= c_im;
                  end else begin
                     a_re <= a_re + c_re;
                     a_im <= a_im + c_im;
                  end
               end
               assign bank_re[E] = b_re;
               assign bank_im[E] = b_im;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_re <= '0;
         rd_im <= '0;
      end else if (32'(rd_addr) < TOT) begin
         rd_re <= bank_re[rd_addr];
         rd_im <= bank_im[rd_addr];
      end else begin
         rd_re <= '0;
         rd_im <= '0;
      end
   end
endmodule

// File: rtl/xcorr_cell.sv
module xcorr_cell #(
   parameter int NI    = 12,
   parameter int NX    = 2,
   parameter int W     = 8,
   parameter int ACC_W = 32,
   parameter int CNT_W = 16,
   localparam int N    = NX * NI,
   localparam int AW   = $clog2(2 * NX * NI * NI)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sync,
   input  logic                    loc_valid,
   input  logic                    loc_flag,
   input  logic signed [W-1:0]     loc_re,
   input  logic signed [W-1:0]     loc_im,
   input  logic                    rem_valid,
   input  logic                    rem_flag,
   input  logic [N*W-1:0]          rem_re,
   input  logic [N*W-1:0]          rem_im,
   input  logic [AW-1:0]           rd_addr,
   output logic signed [ACC_W-1:0] rd_re,
   output logic signed [ACC_W-1:0] rd_im,
   output logic [CNT_W-1:0]        snap_valid,
   output logic [CNT_W-1:0]        snap_flag
);
   localparam int PW = 2 * W + 1;
   localparam int RW = (NI > 1) ? $clog2(NI) : 1;

   if (NI < 2) begin : g_bad_ni
      $error("xcorr_cell: NI must be at least 2");
   end
   if (NX < 1) begin : g_bad_nx
      $error("xcorr_cell: NX must be at least 1");
   end
   if (ACC_W < PW) begin : g_bad_acc
      $error("xcorr_cell: ACC_W must hold one full product");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("xcorr_cell: CNT_W too small");
   end

   logic signed [W-1:0]  rm_re [N], rm_im [N];
   logic signed [W-1:0]  blk_re [N], blk_im [N];
   logic signed [W-1:0]  slot_re [N], slot_im [N];
   logic signed [W-1:0]  ref_re [N], ref_im [N];
   logic signed [W-1:0]  pb_re [N], pb_im [N];
   logic signed [PW-1:0] p_re [N], p_im [N];
   logic                 blk_done, blk_flag, loc_load, loc_flagged;
   logic                 rem_ok, rem_take, rem_flagged, pass_on, held;
   logic [RW-1:0]        rot;
   logic [CNT_W-1:0]     cnt_valid, cnt_flag;
   logic [1:0]           inc_v, inc_f;

   for (genvar n = 0; n < N; n++) begin : g_unpack
      assign rm_re[n] = rem_re[n*W +: W];
      assign rm_im[n] = rem_im[n*W +: W];
      // partner of each slot: the held block during the self pass, else the remote block
      assign pb_re[n] = pass_on ? ref_re[n] : rm_re[n];
      assign pb_im[n] = pass_on ? ref_im[n] : rm_im[n];
   end

   xcorr_local_collect #(.NX(NX), .NI(NI), .W(W)) i_collect (
      .clk(clk), .rst_n(rst_n), .beat_valid(loc_valid), .beat_flag(loc_flag),
      .beat_re(loc_re), .beat_im(loc_im), .blk_done(blk_done), .blk_flag(blk_flag),
      .blk_re(blk_re), .blk_im(blk_im));

   assign loc_load    = blk_done & ~blk_flag;
   assign loc_flagged = blk_done & blk_flag;
   assign rem_ok      = rem_valid & held & ~pass_on;
   assign rem_take    = rem_ok & ~rem_flag;
   assign rem_flagged = rem_ok & rem_flag;

   xcorr_barrel #(.NX(NX), .NI(NI), .W(W), .RW(RW)) i_barrel (
      .clk(clk), .rst_n(rst_n), .load(loc_load), .load_re(blk_re), .load_im(blk_im),
      .rem_take(rem_take), .slot_re(slot_re), .slot_im(slot_im), .ref_re(ref_re),
      .ref_im(ref_im), .rot(rot), .pass_on(pass_on), .held(held));

   xcorr_cmul_array #(.N(N), .W(W), .PW(PW)) i_cmul (
      .a_re(slot_re), .a_im(slot_im), .b_re(pb_re), .b_im(pb_im),
      .p_re(p_re), .p_im(p_im));

   xcorr_acc_bank #(.NX(NX), .NI(NI), .PW(PW), .ACC_W(ACC_W), .RW(RW), .AW(AW)) i_bank (
      .clk(clk), .rst_n(rst_n), .en_loc(pass_on), .en_rem(rem_take), .sync(sync),
      .rot(rot), .p_re(p_re), .p_im(p_im), .rd_addr(rd_addr),
      .rd_re(rd_re), .rd_im(rd_im));

   assign inc_v = {1'b0, loc_load} + {1'b0, rem_take};
   assign inc_f = {1'b0, loc_flagged} + {1'b0, rem_flagged};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_valid  <= '0;
         cnt_flag   <= '0;
         snap_valid <= '0;
         snap_flag  <= '0;
      end else if (sync) begin
         snap_valid <= cnt_valid;
         snap_flag  <= cnt_flag;
         cnt_valid  <= CNT_W'(inc_v);
         cnt_flag   <= CNT_W'(inc_f);
      end else begin
         cnt_valid  <= cnt_valid + CNT_W'(inc_v);
         cnt_flag   <= cnt_flag + CNT_W'(inc_f);
      end
   end
endmodule

// File: rtl/xcorr_cell_chk.sv
module xcorr_cell_chk #(
   parameter int NI    = 12,
   parameter int CNT_W = 16,
   parameter int RW    = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sync,
   input logic             pass_on,
   input logic             loc_load,
   input logic             rem_take,
   input logic [RW-1:0]    rot,
   input logic [CNT_W-1:0] cnt_valid,
   input logic [CNT_W-1:0] cnt_flag,
   input logic [CNT_W-1:0] snap_valid,
   input logic [CNT_W-1:0] snap_flag
);
   AST_ROT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(rot) < NI);  // R5

   AST_LOAD_STARTS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      loc_load |=> pass_on && rot == '0);  // R3

   AST_PASS_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      pass_on && 32'(rot) == NI - 1 && !loc_load |=> !pass_on);  // R3

   AST_REM_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
      rem_take && !loc_load |=> 32'(rot) == ((32'($past(rot)) + 1) % NI));  // R5

   AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !sync |=> $stable(snap_valid) && $stable(snap_flag));  // R9

   AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      sync |=> cnt_valid <= CNT_W'(2) && cnt_flag <= CNT_W'(2));  // R9

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !sync |=> CNT_W'(cnt_valid - $past(cnt_valid)) <= CNT_W'(2));  // R8
endmodule

bind xcorr_cell xcorr_cell_chk #(.NI(NI), .CNT_W(CNT_W), .RW(RW)) i_chk (
   .clk(clk), .rst_n(rst_n), .sync(sync), .pass_on(pass_on), .loc_load(loc_load),
   .rem_take(rem_take), .rot(rot), .cnt_valid(cnt_valid), .cnt_flag(cnt_flag),
   .snap_valid(snap_valid), .snap_flag(snap_flag));

// File: tb/test_xcorr_cell.sv
`timescale 1ns/1ps
module test_xcorr_cell;
   localparam int NI    = 12;
   localparam int NX    = 2;
   localparam int W     = 8;
   localparam int ACC_W = 32;
   localparam int CNT_W = 16;
   localparam int N     = NX * NI;
   localparam int TOT   = 2 * NX * NI * NI;
   localparam int AW    = $clog2(TOT);

   logic clk = 1'b0;
   logic rst_n, sync, loc_valid, loc_flag, rem_valid, rem_flag;
   logic signed [W-1:0] loc_re, loc_im;
   logic [N*W-1:0] rem_re, rem_im;
   logic [AW-1:0] rd_addr;
   logic signed [ACC_W-1:0] rd_re, rd_im;
   logic [CNT_W-1:0] snap_valid, snap_flag;

   always #5 clk = ~clk;

   xcorr_cell #(.NI(NI), .NX(NX), .W(W), .ACC_W(ACC_W), .CNT_W(CNT_W)) i_xcorr_cell (
      .clk(clk), .rst_n(rst_n), .sync(sync), .loc_valid(loc_valid), .loc_flag(loc_flag),
      .loc_re(loc_re), .loc_im(loc_im), .rem_valid(rem_valid), .rem_flag(rem_flag),
      .rem_re(rem_re), .rem_im(rem_im), .rd_addr(rd_addr), .rd_re(rd_re), .rd_im(rd_im),
      .snap_valid(snap_valid), .snap_flag(snap_flag));

   int n_chk = 0, n_fail = 0;
   string cur_req = "R1";

   task automatic check(string tag, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int vidx(int k, int x, int i, int j);
      return ((k * NX + x) * NI + i) * NI + j;
   endfunction

   function automatic int val(int seed, int n, int part);
      return ((seed * 31 + n * 17 + part * 7) % 251) - 125;
   endfunction

   // ---------------- behavioural reference model ----------------
   int mL_re[N], mL_im[N], mS_re[N], mS_im[N];
   int macc_re[TOT], macc_im[TOT], mbk_re[TOT], mbk_im[TOT], d_re[TOT], d_im[TOT];
   int mrot, mpass, mheld, mbeat, mfl, mcv, mcf, msv, msf, e_re, e_im;
   bit chk_on = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < TOT; e++) begin
            macc_re[e] = 0; macc_im[e] = 0; mbk_re[e] = 0; mbk_im[e] = 0;
         end
         mrot = 0; mpass = 0; mheld = 0; mbeat = 0; mfl = 0;
         mcv = 0; mcf = 0; msv = 0; msf = 0; e_re = 0; e_im = 0;
      end else begin
         int dv, df;
         dv = 0; df = 0;
         for (int e = 0; e < TOT; e++) begin d_re[e] = 0; d_im[e] = 0; end
         if (int'(rd_addr) < TOT) begin e_re = mbk_re[rd_addr]; e_im = mbk_im[rd_addr]; end
         else begin e_re = 0; e_im = 0; end
         if (mpass > 0) begin
            for (int x = 0; x < NX; x++)
               for (int j = 0; j < NI; j++) begin
                  int i, ar, ai, br, bi;
                  i = (j + mrot) % NI;
                  ar = mL_re[x*NI+i]; ai = mL_im[x*NI+i];
                  br = mL_re[x*NI+j]; bi = mL_im[x*NI+j];
                  d_re[vidx(0,x,i,j)] += ar*br + ai*bi;
                  d_im[vidx(0,x,i,j)] += ai*br - ar*bi;
               end
            mrot = (mrot + 1) % NI;
            mpass--;
         end else if (mheld != 0 && rem_valid) begin
            if (rem_flag) df++;
            else begin
               dv++;
               for (int x = 0; x < NX; x++)
                  for (int j = 0; j < NI; j++) begin
                     int i, ar, ai, br, bi;
                     i = (j + mrot) % NI;
                     ar = mL_re[x*NI+i]; ai = mL_im[x*NI+i];
                     br = int'($signed(rem_re[(x*NI+j)*W +: W]));
                     bi = int'($signed(rem_im[(x*NI+j)*W +: W]));
                     d_re[vidx(1,x,i,j)] += ar*br + ai*bi;
                     d_im[vidx(1,x,i,j)] += ai*br - ar*bi;
                  end
               mrot = (mrot + 1) % NI;
            end
         end
         if (loc_valid) begin
            mS_re[mbeat] = int'(loc_re); mS_im[mbeat] = int'(loc_im);
            mfl = mfl | int'(loc_flag);
            if (mbeat == N - 1) begin
               if (mfl != 0) df++;
               else begin
                  dv++;
                  mL_re = mS_re; mL_im = mS_im;
                  mrot = 0; mpass = NI; mheld = 1;
               end
               mbeat = 0; mfl = 0;
            end else mbeat++;
         end
         if (sync) begin
            mbk_re = macc_re; mbk_im = macc_im;
            macc_re = d_re; macc_im = d_im;
            msv = mcv; msf = mcf; mcv = dv; mcf = df;
         end else begin
            for (int e = 0; e < TOT; e++) begin
               macc_re[e] += d_re[e]; macc_im[e] += d_im[e];
            end
            mcv += dv; mcf += df;
         end
      end
   end

   // compare away from the active edge
   always @(negedge clk) begin
      if (rst_n && chk_on) begin
         check({cur_req, " R10 R11 rd_re"}, longint'(rd_re), longint'(e_re));
         check({cur_req, " R10 R11 rd_im"}, longint'(rd_im), longint'(e_im));
         check({cur_req, " R8 snap_valid"}, longint'(snap_valid), longint'(msv));
         check({cur_req, " R7 snap_flag"}, longint'(snap_flag), longint'(msf));
      end
   end

   // ---------------- stimulus ----------------
   task automatic loc_block(int seed, int flag_beat);
      for (int b = 0; b < N; b++) begin
         @(negedge clk);
         loc_valid = 1'b1;
         loc_flag  = (b == flag_beat);
         loc_re    = W'(val(seed, b, 0));
         loc_im    = W'(val(seed, b, 1));
      end
      @(negedge clk);
      loc_valid = 1'b0; loc_flag = 1'b0;
   endtask

   task automatic set_rem(int seed);
      for (int n = 0; n < N; n++) begin
         rem_re[n*W +: W] = W'(val(seed, n, 2));
         rem_im[n*W +: W] = W'(val(seed, n, 3));
      end
   endtask

   task automatic rem_block(int seed, bit flg);
      @(negedge clk);
      set_rem(seed); rem_valid = 1'b1; rem_flag = flg;
      @(negedge clk);
      rem_valid = 1'b0; rem_flag = 1'b0;
   endtask

   task automatic pulse_sync();
      @(negedge clk); sync = 1'b1;
      @(negedge clk); sync = 1'b0;
   endtask

   task automatic scan();
      repeat (TOT + 4) @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; sync = 1'b0; loc_valid = 1'b0; loc_flag = 1'b0;
      loc_re = '0; loc_im = '0; rem_valid = 1'b0; rem_flag = 1'b0;
      rem_re = '0; rem_im = '0; rd_addr = '0;
      fork
         forever begin
            @(negedge clk);
            rd_addr <= (int'(rd_addr) >= TOT - 1) ? '0 : rd_addr + 1'b1;
         end
      join_none
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rd_re after reset", longint'(rd_re), 0);
      check("R1 rd_im after reset", longint'(rd_im), 0);
      check("R1 snap_valid after reset", longint'(snap_valid), 0);
      check("R1 snap_flag after reset", longint'(snap_flag), 0);
      chk_on = 1;

      // remote before any local block is held
      cur_req = "R1 R6";
      rem_block(5, 1'b0);
      repeat (3) @(negedge clk);
      pulse_sync();
      scan();
      check("R6 remote without held block not counted", longint'(snap_valid), 0);

      // local self correlation
      cur_req = "R2 R3";
      loc_block(1, -1);
      repeat (NI + 2) @(negedge clk);
      pulse_sync();
      scan();
      check("R8 one valid local block", longint'(snap_valid), 1);

      // remote blocks over more than a full turn, one flagged
      cur_req = "R4 R5 R7";
      for (int k = 0; k <= NI; k++) begin
         rem_block(10 + k, 1'b0);
         if (k == 4) rem_block(99, 1'b1);
      end
      pulse_sync();
      scan();
      check("R8 valid remote count", longint'(snap_valid), NI + 1);
      check("R7 flagged remote count", longint'(snap_flag), 1);

      // flagged local blocks keep the held crosslets
      cur_req = "R2 R7";
      loc_block(2, 5);
      loc_block(4, N - 1);
      rem_block(20, 1'b0);
      pulse_sync();
      scan();
      check("R7 flagged local count", longint'(snap_flag), 2);
      check("R8 only remote valid", longint'(snap_valid), 1);

      // remote during pass is dropped; remote in the sync cycle goes to the new integration
      cur_req = "R6 R9";
      loc_block(3, -1);
      rem_block(30, 1'b0);
      repeat (NI + 2) @(negedge clk);
      @(negedge clk);
      set_rem(31); rem_valid = 1'b1; sync = 1'b1;
      @(negedge clk);
      rem_valid = 1'b0; sync = 1'b0;
      check("R9 sync-cycle remote excluded from snapshot", longint'(snap_valid), 1);
      scan();
      pulse_sync();
      scan();
      check("R9 sync-cycle remote in next integration", longint'(snap_valid), 1);

      chk_on = 0;
      summary();
      $finish;
   end
endmodule